// File: doc/BRIEF.md
# Wavetable Waveform Generator with Counter-Stepped Phase

The block turns a 256-sample table into a periodic 8-bit sample stream whose rate is set by a numeric increment. A 20-bit phase accumulator adds the increment on every clock. Each carry out of that accumulator becomes a one-cycle step pulse. The pulse advances a separate 8-bit phase counter. Together the two form a 28-bit phase: one output period takes 2^28 / increment clocks, so the frequency step is f_clk / 2^28. At a clock near 26.84 MHz that step is about 0.1 Hz. At the top rate of 20 kHz with 256 samples per period, samples change at 5.12 MHz.

The counter value is copied into an address register, and the table is read from that register. The address presented to the table is therefore always the previous, settled count, and never the count that is being updated. A controller replaces the table through load mode, which works as follows:
- Raising the load input gates off the step pulses and clears the phase counter.
- While load mode is active, the output is forced to mid-scale.
- Each write strobe stores one byte at the current count and advances the counter by one.
- When load mode is dropped, the output and the step pulses come back.

The accumulator keeps running through a reload. Only the phase counter restarts.

Top module: `wavetable_nco_gen`

## Requirements
- R1: On every clock after reset, the accumulator is replaced by (accumulator + phase_inc) mod 2^20. A carry out of that sum outside load mode raises step_o for exactly the next cycle, so step_o averages phase_inc / 2^20 pulses per clock.
- R2: Outside load mode, each step_o pulse advances the 8-bit phase counter by one. The counter wraps from 255 to 0, so one output period is 256 step pulses.
- R3: The table address is a register that takes the phase count one clock after it settles. sample_out shows the table entry at that address one clock later, so a step is visible on sample_out three clocks after step_o.
- R4: On the first clock with load_mode high (load state previously inactive), the phase counter is cleared to 0. From then until load mode has ended, carries produce no step_o pulse.
- R5: From the clock after the load state is entered until the clock after it is left, sample_out holds the mid-scale value 0x80.
- R6: While the load state is active, each clock with wr_stb high writes wr_data into the table entry at the current count and advances the count by one. Strobes given outside the load state change neither the table nor the count.
- R7: load_busy rises on the clock after a write at count 0. It falls on the clock after the write at count 255, and it is low whenever the load state is inactive.
- R8: The accumulator is never cleared by load mode, so the carry pattern after a reload continues the pattern from before it.
- R9: After load_mode falls, step pulses resume and sample_out again follows the table from address 0 onward.
- R10: Reset makes sample_out 0x80, load_busy and step_o 0, the accumulator and phase counter 0, and every table entry 0x80.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| phase_inc | input | 20 | Phase increment added every clock |
| load_mode | input | 1 | High to stop stepping and rewrite the table |
| wr_stb | input | 1 | Write strobe, one table byte per high clock in load mode |
| wr_data | input | 8 | Table byte to write |
| sample_out | output | 8 | Current waveform sample, 0x80 while loading |
| step_o | output | 1 | One-cycle pulse on each accumulator carry |
| load_busy | output | 1 | High between the first and the last write of a reload |

## Verification
The bench fills the table with a distinct ramp-like pattern and then runs the generator at several increments:
- An increment that does not divide 2^20 gives irregular carry spacing. This exposes a wrong carry width or a cleared accumulator after a reload.
- Exactly half of full scale gives a step every second clock. This confirms the counter wrap and the three-clock address-to-sample latency.
- An all-ones increment gives a step on almost every clock. This tests back-to-back advances.

Write strobes between reloads check that out-of-mode writes leave the waveform unchanged. A second reload with a different pattern, with idle clocks inside load mode, checks the counter clear, the mid-scale output and the busy window.

// File: rtl/wtg_pkg.sv
package wtg_pkg;
  localparam int ACC_W_DEF = 20;
  localparam int PH_W_DEF  = 8;
  localparam int SMP_W_DEF = 8;

  typedef enum logic [1:0] {
    CNT_HOLD  = 2'd0,
    CNT_CLEAR = 2'd1,
    CNT_ADV   = 2'd2
  } cnt_op_e;
endpackage

// File: rtl/wtg_phase_acc.sv
module wtg_phase_acc #(
  parameter int ACC_W = wtg_pkg::ACC_W_DEF
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [ACC_W-1:0] inc,
  input  logic             hold,
  output logic             step
);
  logic [ACC_W-1:0] acc_q;
  logic [ACC_W:0]   sum_w;

  function automatic logic [ACC_W:0] add_carry(input logic [ACC_W-1:0] a,
                                               input logic [ACC_W-1:0] b);
    return {1'b0, a} + {1'b0, b};
  endfunction

  assign sum_w = add_carry(acc_q, inc);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q <= '0;
      step  <= 1'b0;
    end else begin
      acc_q <= sum_w[ACC_W-1:0];
      step  <= sum_w[ACC_W] & ~hold;
    end
  end

  AST_NO_STEP_IN_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    hold |=> !step) else $error("step while held"); // R4

  AST_ACC_WRAPS: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> acc_q == ACC_W'($past(acc_q) + $past(inc))) else $error("accumulator step wrong"); // R1
endmodule

// File: rtl/wtg_phase_cnt.sv
module wtg_phase_cnt #(
  parameter int PH_W = wtg_pkg::PH_W_DEF
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            clr,
  input  logic            wr_adv,
  input  logic            step_adv,
  output logic [PH_W-1:0] cnt
);
  import wtg_pkg::*;

  cnt_op_e op_w;

  function automatic cnt_op_e pick_op(input logic c, input logic w, input logic s);
    if (c)           return CNT_CLEAR;
    else if (w || s) return CNT_ADV;
    else             return CNT_HOLD;
  endfunction

  function automatic logic [PH_W-1:0] next_cnt(input cnt_op_e o, input logic [PH_W-1:0] v);
    case (o)
      CNT_CLEAR: return '0;
      CNT_ADV:   return v + 1'b1;
      default:   return v;
    endcase
  endfunction

  assign op_w = pick_op(clr, wr_adv, step_adv);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt <= '0;
    else        cnt <= next_cnt(op_w, cnt);
  end

  AST_CNT_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> cnt == '0) else $error("count not cleared"); // R4

  AST_CNT_ADVANCES: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr && (wr_adv || step_adv)) |=> cnt == PH_W'($past(cnt) + 1'b1)) else $error("count not advanced"); // R2

  AST_CNT_STILL: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr && !wr_adv && !step_adv) |=> $stable(cnt)) else $error("count moved"); // R6
endmodule

// File: rtl/wtg_table.sv
module wtg_table #(
  parameter int AW    = wtg_pkg::PH_W_DEF,
  parameter int DW    = wtg_pkg::SMP_W_DEF,
  parameter logic [DW-1:0] INIT = 8'h80
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= INIT;
    end else if (we) begin
      mem[waddr] <= wdata;
    end
  end

  assign rdata = mem[raddr];
endmodule

// File: rtl/wavetable_nco_gen.sv
module wavetable_nco_gen #(
  parameter int ACC_W = wtg_pkg::ACC_W_DEF,
  parameter int PH_W  = wtg_pkg::PH_W_DEF,
  parameter int SMP_W = wtg_pkg::SMP_W_DEF
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [ACC_W-1:0] phase_inc,
  input  logic             load_mode,
  input  logic             wr_stb,
  input  logic [SMP_W-1:0] wr_data,
  output logic [SMP_W-1:0] sample_out,
  output logic             step_o,
  output logic             load_busy
);
  localparam logic [SMP_W-1:0] MID      = SMP_W'(1) << (SMP_W - 1);
  localparam logic [PH_W-1:0]  LAST_IDX = '1;

  logic            ld_q;
  logic            hold_w;
  logic            load_enter_w;
  logic            wr_take_w;
  logic            step_take_w;
  logic [PH_W-1:0] cnt_w;
  logic [PH_W-1:0] addr_q;
  logic [SMP_W-1:0] rd_w;

  assign hold_w       = load_mode | ld_q;
  assign load_enter_w = load_mode & ~ld_q;
  assign wr_take_w    = ld_q & wr_stb;
  assign step_take_w  = step_o & ~hold_w;

  wtg_phase_acc #(.ACC_W(ACC_W)) u_acc (
    .clk(clk), .rst_n(rst_n), .inc(phase_inc), .hold(hold_w), .step(step_o)
  );

  wtg_phase_cnt #(.PH_W(PH_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .clr(load_enter_w), .wr_adv(wr_take_w),
    .step_adv(step_take_w), .cnt(cnt_w)
  );

  wtg_table #(.AW(PH_W), .DW(SMP_W), .INIT(MID)) u_tbl (
    .clk(clk), .rst_n(rst_n), .we(wr_take_w), .waddr(cnt_w), .wdata(wr_data),
    .raddr(addr_q), .rdata(rd_w)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ld_q       <= 1'b0;
      addr_q     <= '0;
      sample_out <= MID;
      load_busy  <= 1'b0;
    end else begin
      ld_q       <= load_mode;
      addr_q     <= cnt_w;
      sample_out <= ld_q ? MID : rd_w;
      if (!ld_q)          load_busy <= 1'b0;
      else if (wr_take_w) load_busy <= (cnt_w != LAST_IDX);
    end
  end

  AST_MIDSCALE_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    ld_q |=> sample_out == MID) else $error("output not mid-scale in load"); // R5

  AST_BUSY_OUTSIDE: assert property (@(posedge clk) disable iff (!rst_n)
    !ld_q |=> !load_busy) else $error("busy outside load"); // R7

  AST_BUSY_RISE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(load_busy) |-> $past(wr_take_w)) else $error("busy rose without write"); // R7

  AST_ADDR_SETTLED: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> addr_q == $past(cnt_w)) else $error("address not previous count"); // R3
endmodule

// File: tb/test_wavetable_nco_gen.sv
module test_wavetable_nco_gen;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [19:0] phase_inc = '0;
  logic        load_mode = 1'b0;
  logic        wr_stb = 1'b0;
  logic [7:0]  wr_data = '0;
  logic [7:0]  sample_out;
  logic        step_o;
  logic        load_busy;

  int n_chk = 0;
  int n_fail = 0;
  string cur_tag = "R10";

  always #2.5 clk = ~clk;

  wavetable_nco_gen i_wavetable_nco_gen (
    .clk(clk), .rst_n(rst_n), .phase_inc(phase_inc), .load_mode(load_mode),
    .wr_stb(wr_stb), .wr_data(wr_data), .sample_out(sample_out),
    .step_o(step_o), .load_busy(load_busy)
  );

  // reference state derived from the requirements
  logic [19:0] m_acc;
  logic        m_step, m_ld, m_busy;
  logic [7:0]  m_cnt, m_addr, m_out;
  logic [7:0]  m_tbl [256];
  logic [9:0]  exp_q [$];

  always @(posedge clk) begin
    if (!rst_n) begin
      m_acc = '0; m_step = 0; m_ld = 0; m_busy = 0;
      m_cnt = '0; m_addr = '0; m_out = 8'h80;
      for (int i = 0; i < 256; i++) m_tbl[i] = 8'h80;
      exp_q.delete();
    end else begin
      logic [20:0] s;
      logic hold, wacc, n_step, n_busy;
      logic [7:0] n_cnt, n_out;
      hold   = load_mode | m_ld;
      s      = {1'b0, m_acc} + {1'b0, phase_inc};
      n_step = s[20] & ~hold;                                  // R1
      wacc   = m_ld & wr_stb;
      if (load_mode && !m_ld)      n_cnt = 8'd0;               // R4
      else if (wacc)               n_cnt = m_cnt + 8'd1;       // R6
      else if (m_step && !hold)    n_cnt = m_cnt + 8'd1;       // R2
      else                         n_cnt = m_cnt;
      n_out  = m_ld ? 8'h80 : m_tbl[m_addr];                   // R3 R5
      n_busy = !m_ld ? 1'b0 : (wacc ? (m_cnt != 8'd255) : m_busy); // R7
      if (wacc) m_tbl[m_cnt] = wr_data;
      m_acc = s[19:0]; m_step = n_step; m_cnt = n_cnt;
      m_addr = m_cnt_prev_fix(n_cnt);
      m_out = n_out; m_busy = n_busy; m_ld = load_mode;
      exp_q.push_back({n_out, n_busy, n_step});
    end
  end

  // the address register takes the count that held before this edge
  logic [7:0] cnt_before;
  function automatic logic [7:0] m_cnt_prev_fix(input logic [7:0] unused_n);
    return cnt_before;
  endfunction
  always @(negedge clk) cnt_before = m_cnt;

  // monitor: pops one expected item per cycle
  always @(negedge clk) begin
    if (rst_n && exp_q.size() > 0) begin
      logic [9:0] e;
      e = exp_q.pop_front();
      n_chk++;
      if ({sample_out, load_busy, step_o} !== e) begin
        n_fail++;
        $display("FAIL %s: out=%h busy=%b step=%b expected out=%h busy=%b step=%b",
                 cur_tag, sample_out, load_busy, step_o, e[9:2], e[1], e[0]);
      end
    end
  end

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic cycles(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic reload(input int seed, input int mult);
    @(negedge clk); load_mode = 1'b1; cur_tag = "R4 R5 R8";
    cycles(3);
    cur_tag = "R6 R7";
    for (int i = 0; i < 256; i++) begin
      wr_stb = 1'b1; wr_data = 8'((i * mult + seed) & 255);
      @(negedge clk);
      if (i == 0)   check("R7 busy after first write", load_busy, 1);
      if (i == 255) check("R7 busy after last write", load_busy, 0);
      if (i % 37 == 5) begin wr_stb = 1'b0; @(negedge clk); end
    end
    wr_stb = 1'b0;
    check("R5 mid-scale in load", sample_out, 8'h80);
    cycles(2);
    load_mode = 1'b0; cur_tag = "R9";
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    cycles(3);
    check("R10 reset sample", sample_out, 8'h80);
    check("R10 reset busy", load_busy, 0);
    check("R10 reset step", step_o, 0);
    rst_n = 1'b1;
    phase_inc = 20'h61A3B;
    cur_tag = "R1 R2 R3 R10";
    cycles(40);
    reload(5, 37);
    cycles(6);
    cur_tag = "R1 R2 R3 R9";
    cycles(1500);
    phase_inc = 20'h80000; cur_tag = "R2 R3";
    cycles(600);
    phase_inc = 20'hFFFFF; cur_tag = "R1 R2";
    cycles(600);
    cur_tag = "R6 ignored writes";
    for (int i = 0; i < 50; i++) begin
      wr_stb = 1'b1; wr_data = 8'(i * 11); @(negedge clk);
    end
    wr_stb = 1'b0;
    check("R6 busy stays low outside load", load_busy, 0);
    cur_tag = "R6 table unchanged";
    cycles(600);
    phase_inc = 20'h2B7C1;
    cur_tag = "R8";
    cycles(17);
    reload(200, 13);
    cycles(4);
    cur_tag = "R8 R9";
    cycles(1200);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule